// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is the bus-facing command interpreter of a byte-wide flash device. It watches a chip-enable, write-enable and output-enable strobe triple that arrives asynchronously. It resamples the strobes on an internal clock and recovers write cycles from them, latching the address at the start of each write and the data at its end. Written bytes are decoded as one- or two-cycle commands that pick among array reads, the identifier readout, chip erase and byte program. The decoder issues start and abort pulses to the embedded program/erase sequencer and waits for that sequencer's completion pulse.

The same state selects what a read cycle returns. That is the array byte supplied from outside, one of two identifier bytes, or a status byte whose top bit signals completion and whose bit 6 flips on every finished read while an operation runs. Two level inputs gate the register. One says that high programming voltage is present and the other signals low-supply lockout. Without the first, or with the second, the register sits in array-read mode and accepts no command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is taken only while chip-enable and write-enable are both low and output-enable is high. The address is latched when the later of the two enables falls and the data when the earlier one rises, so either enable may bound the write.
- R2: While vppHigh is low the decoder stays in array-read mode and every command write is ignored. A running operation is aborted.
- R3: A write of 00h or FFh selects array-read mode. In every state except program setup, one such write is enough. From a running operation it also raises seqAbort for one clock and drops busy.
- R4: 80h or 90h enters identifier mode. A read at address 0 returns 01h, at address 1 returns 29h and at any other address 00h. Both identifier bytes have odd parity.
- R5: Two consecutive 30h writes start a chip erase with a single seqStartErase pulse, and busy rises. Any other byte written after the first 30h is decoded as a new command and starts nothing.
- R6: 10h or 50h enters program setup. The next write (not 00h or FFh) raises seqStartProg once, and presents the latched address on progAddr and the latched data on progData.
- R7: In program setup a first 00h/FFh write is taken as null program data. It starts nothing and leaves array reads unchanged. A second consecutive 00h/FFh write returns to array-read mode.
- R8: While lowVcc is high the decoder is forced to array-read mode and every write is ignored. A running operation gets one seqAbort pulse.
- R9: While an operation runs, every read returns a status byte. Bit 7 is the complement of bit 7 of the program data, or 0 during erase. Bit 6 is 0 on the first read after the start and flips after each completed read. Bits 5:0 are zero. A seqDone pulse ends the operation and restores array reads.
- R10: A byte that is no command leaves array-read mode and identifier mode unchanged. Outside these two modes it returns the decoder to array-read mode. While an operation runs, writes other than 00h/FFh are ignored.
- R11: A write pulse that is already active when reset is released is never accepted as a command.
- R12: seqStartErase, seqStartProg and seqAbort are each one clock wide, and no two are high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low, asynchronous |
| weN | input | 1 | Write enable, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Bus address |
| dataIn | input | 8 | Bus write data |
| arrayData | input | 8 | Array byte at the current address |
| vppHigh | input | 1 | High programming voltage is present |
| lowVcc | input | 1 | Low-supply lockout |
| seqDone | input | 1 | Completion pulse from the embedded sequencer |
| dataOut | output | 8 | Byte presented for a read cycle |
| progAddr | output | ADDR_W | Address latched for programming |
| progData | output | 8 | Data latched for programming |
| seqStartErase | output | 1 | One-clock request to start chip erase |
| seqStartProg | output | 1 | One-clock request to start byte program |
| seqAbort | output | 1 | One-clock request to abort the running operation |
| busy | output | 1 | An embedded operation is in progress |

## Verification
A wrong command state is visible on the very next read cycle, because dataOut is chosen directly from the state. A wrong state also shows on busy and on the sequencer pulses about four clocks after the write strobe rises, which is the length of the resampling path. A lost or doubled start or abort pulse appears as a miscount against the reference model within the same transaction. Each toggle step of the status byte is compared against the model, read by read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_READ,
    ST_AUTOSEL,
    ST_ERASE_SETUP,
    ST_ERASE_RUN,
    ST_PROG_SETUP,
    ST_PROG_NULL,
    ST_PROG_RUN
  } cmdState_t;

  typedef enum logic [1:0] {
    SRC_ARRAY,
    SRC_IDENT,
    SRC_PROG_STAT,
    SRC_ERASE_STAT
  } readSrc_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RESET,
    OP_IDENT,
    OP_ERASE,
    OP_PROG
  } cmdOp_t;

  typedef struct packed {
    readSrc_t readSrc;
    logic     loadProg;
    logic     clearToggle;
  } ctrlStrobe_t;

  function automatic cmdOp_t decodeOp(logic [CMD_W-1:0] code);
    case (code)
      8'h00, 8'hFF: return OP_RESET;
      8'h80, 8'h90: return OP_IDENT;
      8'h30:        return OP_ERASE;
      8'h10, 8'h50: return OP_PROG;
      default:      return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/flash_cmd_bus.sv
module flash_cmd_bus
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  dataIn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CMD_W-1:0]  wrData,
  output logic              wrValid,
  output logic              rdEnd
);

  // Each stage holds {ce, we, oe}. Reset value is the "write active" pattern,
  // so a pulse already low at reset release never shows a start edge.
  localparam logic [2:0] SYNC_RESET = 3'b001;

  logic [2:0] syncSh [SYNC_STAGES];
  logic ceS, weS, oeS;
  logic wrAct, wrActD, wrOpen, wrBegin, wrEnd;
  logic rdAct, rdActD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncSh[s] <= SYNC_RESET;
    end else begin
      syncSh[0] <= {ceN, weN, oeN};
      for (int s = 1; s < SYNC_STAGES; s++) syncSh[s] <= syncSh[s-1];
    end
  end

  assign {ceS, weS, oeS} = syncSh[SYNC_STAGES-1];

  assign wrAct   = !ceS && !weS && oeS;
  assign wrBegin = wrAct && !wrActD;
  assign wrEnd   = !wrAct && wrActD;
  assign rdAct   = !ceS && !oeS && weS;
  assign rdEnd   = rdActD && !rdAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActD  <= 1'b1;
      wrOpen  <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
      wrValid <= 1'b0;
      rdActD  <= 1'b0;
    end else begin
      wrActD  <= wrAct;
      rdActD  <= rdAct;
      wrValid <= 1'b0;
      if (wrBegin) begin
        wrAddr <= addr;
        wrOpen <= 1'b1;
      end
      if (wrEnd) begin
        wrOpen <= 1'b0;
        if (wrOpen) begin
          wrData  <= dataIn;
          wrValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [CMD_W-1:0] wrData,
  input  logic             vppHigh,
  input  logic             lowVcc,
  input  logic             seqDone,
  output ctrlStrobe_t      strobe,
  output logic             seqStartErase,
  output logic             seqStartProg,
  output logic             seqAbort,
  output logic             busy
);

  cmdState_t state, nxt;
  cmdOp_t    op;
  logic      goErase, goProg, doAbort, running, inhibit;

  function automatic cmdState_t freshCmd(cmdOp_t o, cmdState_t keep);
    case (o)
      OP_RESET: return ST_READ;
      OP_IDENT: return ST_AUTOSEL;
      OP_ERASE: return ST_ERASE_SETUP;
      OP_PROG:  return ST_PROG_SETUP;
      default:  return keep;
    endcase
  endfunction

  assign inhibit = !vppHigh || lowVcc;
  assign running = (state == ST_ERASE_RUN) || (state == ST_PROG_RUN);
  assign op      = decodeOp(wrData);

  always_comb begin
    nxt     = state;
    goErase = 1'b0;
    goProg  = 1'b0;
    doAbort = 1'b0;
    if (inhibit) begin
      nxt     = ST_READ;
      doAbort = running;
    end else if (running && seqDone) begin
      nxt = ST_READ;
    end else if (wrValid) begin
      case (state)
        ST_READ, ST_AUTOSEL: nxt = freshCmd(op, state);
        ST_ERASE_SETUP: begin
          if (op == OP_ERASE) begin
            nxt     = ST_ERASE_RUN;
            goErase = 1'b1;
          end else begin
            nxt = freshCmd(op, ST_READ);
          end
        end
        ST_PROG_SETUP: begin
          if (op == OP_RESET) begin
            nxt = ST_PROG_NULL;
          end else begin
            nxt    = ST_PROG_RUN;
            goProg = 1'b1;
          end
        end
        ST_PROG_NULL: nxt = freshCmd(op, ST_READ);
        ST_ERASE_RUN, ST_PROG_RUN: begin
          if (op == OP_RESET) begin
            nxt     = ST_READ;
            doAbort = 1'b1;
          end
        end
        default: nxt = ST_READ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_AUTOSEL:   strobe.readSrc = SRC_IDENT;
      ST_PROG_RUN:  strobe.readSrc = SRC_PROG_STAT;
      ST_ERASE_RUN: strobe.readSrc = SRC_ERASE_STAT;
      default:      strobe.readSrc = SRC_ARRAY;
    endcase
    strobe.loadProg    = goProg;
    strobe.clearToggle = goProg || goErase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_READ;
      seqStartErase <= 1'b0;
      seqStartProg  <= 1'b0;
      seqAbort      <= 1'b0;
    end else begin
      state         <= nxt;
      seqStartErase <= goErase;
      seqStartProg  <= goProg;
      seqAbort      <= doAbort;
    end
  end

  assign busy = running;

  AST_NO_VPP_READ: assert property (@(posedge clk) disable iff (!rstN)
    !vppHigh |=> (state == ST_READ)); // R2

  AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    lowVcc |=> (state == ST_READ && !busy)); // R8

  AST_ERASE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    seqStartErase |-> (state == ST_ERASE_RUN && $past(state) == ST_ERASE_SETUP)); // R5

  AST_PROG_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    seqStartProg |-> (state == ST_PROG_RUN && $past(state) == ST_PROG_SETUP)); // R6

  AST_ABORT_FROM_RUN: assert property (@(posedge clk) disable iff (!rstN)
    seqAbort |-> (state == ST_READ &&
                  ($past(state) == ST_ERASE_RUN || $past(state) == ST_PROG_RUN))); // R3

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seqStartErase, seqStartProg, seqAbort})); // R12

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W = 18,
  parameter logic [CMD_W-1:0] MFR_ID = 8'h01,
  parameter logic [CMD_W-1:0] DEV_ID = 8'h29
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CMD_W-1:0]  wrData,
  input  logic              rdEnd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  arrayData,
  output logic [CMD_W-1:0]  dataOut,
  output logic [ADDR_W-1:0] progAddr,
  output logic [CMD_W-1:0]  progData
);

  localparam int LOW_W = CMD_W - 2;

  logic toggleBit;
  logic statusSel;
  logic [CMD_W-1:0] identByte;

  assign statusSel = (strobe.readSrc == SRC_PROG_STAT) || (strobe.readSrc == SRC_ERASE_STAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr  <= '0;
      progData  <= '0;
      toggleBit <= 1'b0;
    end else begin
      if (strobe.loadProg) begin
        progAddr <= wrAddr;
        progData <= wrData;
      end
      if (strobe.clearToggle) toggleBit <= 1'b0;
      else if (rdEnd && statusSel) toggleBit <= !toggleBit;
    end
  end

  always_comb begin
    if (addr == '0)                identByte = MFR_ID;
    else if (addr == ADDR_W'(1))   identByte = DEV_ID;
    else                           identByte = '0;
  end

  always_comb begin
    case (strobe.readSrc)
      SRC_IDENT:      dataOut = identByte;
      SRC_PROG_STAT:  dataOut = {!progData[CMD_W-1], toggleBit, {LOW_W{1'b0}}};
      SRC_ERASE_STAT: dataOut = {1'b0, toggleBit, {LOW_W{1'b0}}};
      default:        dataOut = arrayData;
    endcase
  end

  AST_IDENT_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readSrc == SRC_IDENT && (addr == '0 || addr == ADDR_W'(1))) |-> (^dataOut)); // R4

  AST_PROG_DATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.readSrc == SRC_PROG_STAT && !strobe.loadProg) |=> $stable(progData)); // R6

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int              ADDR_W      = 18,
  parameter int              SYNC_STAGES = 2,
  parameter logic [CMD_W-1:0] MFR_ID     = 8'h01,
  parameter logic [CMD_W-1:0] DEV_ID     = 8'h29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CMD_W-1:0]  dataIn,
  input  logic [CMD_W-1:0]  arrayData,
  input  logic              vppHigh,
  input  logic              lowVcc,
  input  logic              seqDone,
  output logic [CMD_W-1:0]  dataOut,
  output logic [ADDR_W-1:0] progAddr,
  output logic [CMD_W-1:0]  progData,
  output logic              seqStartErase,
  output logic              seqStartProg,
  output logic              seqAbort,
  output logic              busy
);

  logic [ADDR_W-1:0] wrAddr;
  logic [CMD_W-1:0]  wrData;
  logic              wrValid, rdEnd;
  ctrlStrobe_t       strobe;

  flash_cmd_bus #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) bus_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn),
    .wrAddr(wrAddr), .wrData(wrData), .wrValid(wrValid), .rdEnd(rdEnd)
  );

  flash_cmd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .vppHigh(vppHigh), .lowVcc(lowVcc), .seqDone(seqDone),
    .strobe(strobe), .seqStartErase(seqStartErase), .seqStartProg(seqStartProg),
    .seqAbort(seqAbort), .busy(busy)
  );

  flash_cmd_dpath #(.ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdEnd(rdEnd), .addr(addr), .arrayData(arrayData),
    .dataOut(dataOut), .progAddr(progAddr), .progData(progData)
  );

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  localparam int AW = 18;
  localparam int M_READ = 0, M_AUTO = 1, M_ESET = 2, M_ERUN = 3,
                 M_PSET = 4, M_PNULL = 5, M_PRUN = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, ceN, weN, oeN, vppHigh, lowVcc, seqDone;
  logic [AW-1:0] addr;
  logic [7:0]    dataIn, arrayData, dataOut, progData;
  logic [AW-1:0] progAddr;
  logic          seqStartErase, seqStartProg, seqAbort, busy;

  assign arrayData = addr[7:0] ^ 8'hA5;

  flash_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .arrayData(arrayData), .vppHigh(vppHigh), .lowVcc(lowVcc),
    .seqDone(seqDone), .dataOut(dataOut), .progAddr(progAddr), .progData(progData),
    .seqStartErase(seqStartErase), .seqStartProg(seqStartProg), .seqAbort(seqAbort),
    .busy(busy)
  );

  int vectors = 0, miscompares = 0;
  int nErase = 0, nProg = 0, nAbort = 0, pulseErr = 0;
  int eErase = 0, eProg = 0, eAbort = 0;
  int mMode = M_READ;
  int tog = 0;
  logic [AW-1:0] ePA = '0;
  logic [7:0]    ePD = '0;
  logic pE = 0, pP = 0, pA = 0;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock pulse monitor (R12)
  always @(negedge clk) begin
    if (rstN) begin
      if (seqStartErase) nErase++;
      if (seqStartProg)  nProg++;
      if (seqAbort)      nAbort++;
      if ((seqStartErase && pE) || (seqStartProg && pP) || (seqAbort && pA) ||
          (int'(seqStartErase) + int'(seqStartProg) + int'(seqAbort) > 1))
        pulseErr++;
      pE = seqStartErase; pP = seqStartProg; pA = seqAbort;
    end
  end

  function automatic int cls(logic [7:0] d);
    case (d)
      8'h00, 8'hFF: return 1;
      8'h80, 8'h90: return 2;
      8'h30:        return 3;
      8'h10, 8'h50: return 4;
      default:      return 0;
    endcase
  endfunction

  function automatic int freshMode(int c, int keep);
    if (c == 1) return M_READ;
    if (c == 2) return M_AUTO;
    if (c == 3) return M_ESET;
    if (c == 4) return M_PSET;
    return keep;
  endfunction

  task automatic modelWrite(logic [AW-1:0] a, logic [7:0] d);
    int c = cls(d);
    if (mMode == M_READ || mMode == M_AUTO) mMode = freshMode(c, mMode);
    else if (mMode == M_ESET) begin
      if (c == 3) begin mMode = M_ERUN; eErase++; tog = 0; end
      else mMode = freshMode(c, M_READ);
    end else if (mMode == M_PSET) begin
      if (c == 1) mMode = M_PNULL;
      else begin mMode = M_PRUN; eProg++; ePA = a; ePD = d; tog = 0; end
    end else if (mMode == M_PNULL) mMode = freshMode(c, M_READ);
    else if (c == 1) begin mMode = M_READ; eAbort++; end
  endtask

  function automatic logic [7:0] expRead(logic [AW-1:0] a);
    if (mMode == M_AUTO) return (a == 0) ? 8'h01 : (a == 1) ? 8'h29 : 8'h00;
    if (mMode == M_PRUN) return {~ePD[7], tog[0], 6'b0};
    if (mMode == M_ERUN) return {1'b0, tog[0], 6'b0};
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  // ceCtl: CE bounds the pulse; a2/d: address after start and final data.
  task automatic busWrite(logic [AW-1:0] a, logic [7:0] d, bit ceCtl, bit oeLow,
                          logic [AW-1:0] a2, logic [7:0] dEarly);
    bit ok = !oeLow && vppHigh && !lowVcc;
    addr = a; dataIn = dEarly; oeN = oeLow ? 1'b0 : 1'b1;
    if (ceCtl) begin weN = 0; cyc(3); ceN = 0; end
    else begin ceN = 0; cyc(3); weN = 0; end
    cyc(6);
    addr = a2; dataIn = d;
    cyc(6);
    if (ceCtl) ceN = 1; else weN = 1;
    cyc(6);
    ceN = 1; weN = 1; oeN = 1;
    cyc(4);
    if (ok) modelWrite(a, d);
  endtask

  task automatic wr(logic [7:0] d);
    busWrite('0, d, 0, 0, '0, d);
  endtask

  task automatic rdChk(string req, logic [AW-1:0] a);
    logic [7:0] v;
    logic [7:0] e = expRead(a);
    addr = a; ceN = 0; oeN = 0;
    cyc(3);
    @(negedge clk) v = dataOut;
    oeN = 1; ceN = 1;
    cyc(5);
    chk(req, v, e);
    if (mMode == M_PRUN || mMode == M_ERUN) tog ^= 1;
  endtask

  task automatic counts(string req);
    chk({req, " erase starts"}, nErase, eErase);
    chk({req, " program starts"}, nProg, eProg);
    chk({req, " aborts"}, nAbort, eAbort);
    chk({req, " busy"}, busy, (mMode == M_ERUN || mMode == M_PRUN));
  endtask

  task automatic doneSeq();
    @(negedge clk) seqDone = 1;
    @(negedge clk) seqDone = 0;
    cyc(3);
    mMode = M_READ;
  endtask

  initial begin
    // R11: power-up with a write pulse already active
    rstN = 0; ceN = 0; weN = 0; oeN = 1; vppHigh = 1; lowVcc = 0; seqDone = 0;
    addr = '0; dataIn = 8'h90;
    cyc(5); rstN = 1;
    cyc(6); weN = 1; cyc(6); ceN = 1; cyc(6);
    rdChk("R11 power-up write ignored", 0);
    counts("R11");

    // R4 identifier mode
    wr(8'h90);
    rdChk("R4 maker id", 0);
    rdChk("R4 device id", 1);
    rdChk("R4 other address", 7);
    addr = 0; #1 chk("R4 odd parity maker", ^dataOut, 1);
    addr = 1; #1 chk("R4 odd parity device", ^dataOut, 1);
    // R10 unknown code keeps identifier mode
    wr(8'h77);
    rdChk("R10 ident kept", 0);
    wr(8'h00);
    rdChk("R3 back to array", 0);
    wr(8'h77);
    rdChk("R10 read kept", 2);
    wr(8'h80);
    rdChk("R4 80h enters ident", 1);
    wr(8'hFF);
    rdChk("R3 FFh to array", 1);

    // R1 write with output-enable low is ignored
    busWrite('0, 8'h90, 0, 1, '0, 8'h90);
    rdChk("R1 oe-low write ignored", 0);

    // R6/R1 program, address latched at start, data at end
    wr(8'h50);
    busWrite(18'h00123, 8'h3C, 0, 0, 18'h003FF, 8'h11);
    chk("R1 address at start", progAddr, ePA);
    chk("R1 data at end", progData, ePD);
    counts("R6");
    rdChk("R9 prog status 1", 4);
    rdChk("R9 prog status 2", 4);
    rdChk("R9 prog status 3", 4);
    wr(8'h77);
    counts("R10 ignored while running");
    doneSeq();
    counts("R9 done");
    rdChk("R9 array after done", 0);

    // R1 CE-bounded write, R3 abort
    wr(8'h10);
    busWrite(18'h00055, 8'hC3, 1, 0, 18'h00055, 8'hC3);
    chk("R1 ce-bounded data", progData, 8'hC3);
    chk("R1 ce-bounded address", progAddr, 18'h00055);
    rdChk("R9 prog status bit7 low", 0);
    rdChk("R9 prog status toggled", 0);
    wr(8'hFF);
    counts("R3 abort program");

    // R7 program setup with reset
    wr(8'h10);
    wr(8'hFF);
    counts("R7 first reset");
    rdChk("R7 array after null data", 3);
    wr(8'h00);
    wr(8'h90);
    rdChk("R7 second reset left setup", 0);
    counts("R7 no start");
    wr(8'h00);

    // R5 erase
    wr(8'h30);
    wr(8'h30);
    counts("R5 erase start");
    rdChk("R9 erase status 1", 9);
    rdChk("R9 erase status 2", 9);
    wr(8'h00);
    counts("R3 abort erase");
    wr(8'h30);
    wr(8'h90);
    rdChk("R5 setup then other code", 1);
    counts("R5 no erase");
    wr(8'hFF);

    // R8 lockout
    wr(8'h30); wr(8'h30);
    @(negedge clk) lowVcc = 1;
    cyc(3);
    if (mMode == M_ERUN || mMode == M_PRUN) eAbort++;
    mMode = M_READ;
    counts("R8 lockout abort");
    wr(8'h90);
    rdChk("R8 write ignored", 0);
    @(negedge clk) lowVcc = 0;
    cyc(3);

    // R2 no programming voltage
    @(negedge clk) vppHigh = 0;
    cyc(3);
    wr(8'h90);
    rdChk("R2 ident ignored", 0);
    wr(8'h10); busWrite(18'h00011, 8'h22, 0, 0, 18'h00011, 8'h22);
    counts("R2 program ignored");
    @(negedge clk) vppHigh = 1;
    cyc(3);
    wr(8'h10); busWrite(18'h00012, 8'h81, 0, 0, 18'h00012, 8'h81);
    counts("R6 program again");
    @(negedge clk) vppHigh = 0;
    cyc(3);
    eAbort++; mMode = M_READ;
    counts("R2 vpp drop aborts");
    @(negedge clk) vppHigh = 1;
    cyc(3);

    chk("R12 pulse shape", pulseErr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all R): run incomplete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule